// File: doc/BRIEF.md
# Two-Delta Stride Value Predictor

This block forecasts the next result of an instruction from the results it produced before. It holds a direct-mapped table indexed by the instruction address. Each row keeps the most recent result, a candidate stride and a confirmed stride. A lookup port returns the most recent result plus the confirmed stride. An update port takes the real result once it is known. The update records the new difference as the candidate, and it promotes that difference to the confirmed stride only if it equals the candidate already stored.

Because a new stride needs two matching differences in a row, a single irregular step in an otherwise regular sequence leaves the prediction stride alone. Constant sequences settle on a stride of zero. Counting sequences settle on their step. Negative steps and 64-bit wraparound are handled by plain two's-complement arithmetic.

Top module: `stride_value_predictor`

## Requirements
- R1: After reset every row is invalid, so a lookup at any address reports no hit and a prediction of zero.
- R2: The row index is address bits [ALIGN+IDX_W-1:ALIGN] (bits [5:2] by default) and the tag is all address bits above them. A lookup hits only when the indexed row is valid and its tag equals the address tag. On a miss the prediction output is zero.
- R3: On a hit the prediction equals the stored last result plus the confirmed stride, modulo 2^64.
- R4: An update that hits its row sets the candidate stride to (new result minus stored last result) and sets the last result to the new result.
- R5: On such an update, the confirmed stride takes the new difference only when it equals the stored candidate stride. Otherwise the confirmed stride keeps its value, so a one-off jump does not change it.
- R6: An update that misses (invalid row or different tag) claims the row. It sets valid, writes the tag, sets the last result to the new result and clears both strides to zero. An address that shared the row then misses.
- R7: A constant sequence predicts the same value. An arithmetic sequence predicts its next term once three results have been recorded.
- R8: Negative strides and differences that wrap past 2^64 give correct predictions.
- R9: A lookup sees the table as it was before any update in the same cycle. An update takes effect on the next cycle, and without an update the table does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_pc | input | PC_W | Address of the instruction being predicted |
| lk_hit | output | 1 | Lookup found a valid row with a matching tag |
| lk_pred | output | 64 | Predicted result (zero on a miss) |
| up_en | input | 1 | Update strobe |
| up_pc | input | PC_W | Address of the instruction whose result is reported |
| up_value | input | 64 | Actual result |

## Verification
The hardest case to reach from the ports is a row where the candidate and confirmed strides differ. This needs a settled sequence followed by a single irregular step. After that step the confirmed stride must survive, and it must also survive the following regular step, whose difference does not match the now-disturbed candidate. The stimulus builds that sequence on purpose. It also drives two addresses that alias to the same row to force eviction, and it issues a lookup in the same cycle as an update to the same address. A randomised mix over aliasing addresses, compared every cycle against a behavioural model, covers the remaining interleavings.

// File: rtl/svp_pkg.sv
package svp_pkg;
    localparam int unsigned SVP_VAL_W = 64;

    typedef logic [SVP_VAL_W-1:0] svp_word_t;

    typedef struct packed {
        svp_word_t last;
        svp_word_t s1;
        svp_word_t s2;
    } svp_vals_t;
endpackage

// File: rtl/svp_index.sv
module svp_index #(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned ALIGN = 2,
    localparam int unsigned TAG_W = PC_W - ALIGN - IDX_W
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx,
    output logic [TAG_W-1:0] tag
);
    assign idx = pc[ALIGN +: IDX_W];
    assign tag = pc[PC_W-1 -: TAG_W];

    logic unused_low;
    if (ALIGN > 0) begin : g_low
        assign unused_low = ^pc[ALIGN-1:0];
    end else begin : g_nolow
        assign unused_low = 1'b0;
    end
endmodule

// File: rtl/svp_next.sv
module svp_next
    import svp_pkg::*;
(
    input  logic      hit,
    input  svp_vals_t old_v,
    input  svp_word_t value,
    output svp_vals_t new_v
);
    svp_word_t diff;

    always_comb begin
        diff  = value - old_v.last;
        new_v = old_v;
        if (!hit) begin
            new_v.last = value;
            new_v.s1   = '0;
            new_v.s2   = '0;
        end else begin
            new_v.last = value;
            new_v.s1   = diff;
            if (diff == old_v.s1) begin
                new_v.s2 = diff;
            end
        end
    end
endmodule

// File: rtl/stride_value_predictor.sv
module stride_value_predictor
    import svp_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned ALIGN = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [PC_W-1:0]      lk_pc,
    output logic                 lk_hit,
    output logic [SVP_VAL_W-1:0] lk_pred,
    input  logic                 up_en,
    input  logic [PC_W-1:0]      up_pc,
    input  logic [SVP_VAL_W-1:0] up_value
);
    localparam int unsigned IDX_W = $clog2(DEPTH);
    localparam int unsigned TAG_W = PC_W - ALIGN - IDX_W;

    typedef struct packed {
        logic             valid;
        logic [TAG_W-1:0] tag;
        svp_vals_t        v;
    } row_t;

    row_t [DEPTH-1:0] tbl_q, tbl_d;

    logic [IDX_W-1:0] lk_idx, up_idx;
    logic [TAG_W-1:0] lk_tag, up_tag;
    row_t             lk_row, up_row;
    logic             up_hit;
    svp_vals_t        up_new;

    svp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) i_lk_index (
        .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
    );
    svp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) i_up_index (
        .pc(up_pc), .idx(up_idx), .tag(up_tag)
    );

    assign lk_row  = tbl_q[lk_idx];
    assign lk_hit  = lk_row.valid && (lk_row.tag == lk_tag);
    assign lk_pred = lk_hit ? (lk_row.v.last + lk_row.v.s2) : '0;

    assign up_row = tbl_q[up_idx];
    assign up_hit = up_row.valid && (up_row.tag == up_tag);

    svp_next i_next (
        .hit(up_hit), .old_v(up_row.v), .value(up_value), .new_v(up_new)
    );

    always_comb begin
        tbl_d = tbl_q;
        if (up_en) begin
            tbl_d[up_idx].valid = 1'b1;
            tbl_d[up_idx].tag   = up_tag;
            tbl_d[up_idx].v     = up_new;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_q <= '0;
        end else begin
            tbl_q <= tbl_d;
        end
    end

    AST_ROW_CLAIMED: assert property (@(posedge clk) disable iff (!rst_n)
        up_en |=> tbl_q[$past(up_idx)].valid && tbl_q[$past(up_idx)].tag == $past(up_tag)); // R6

    AST_LAST_WRITTEN: assert property (@(posedge clk) disable iff (!rst_n)
        up_en |=> tbl_q[$past(up_idx)].v.last == $past(up_value)); // R4

    AST_STRIDE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && up_hit && ((up_value - up_row.v.last) != up_row.v.s1))
        |=> tbl_q[$past(up_idx)].v.s2 == $past(up_row.v.s2)); // R5

    AST_FRESH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (up_en && !up_hit) |=> tbl_q[$past(up_idx)].v.s1 == '0 && tbl_q[$past(up_idx)].v.s2 == '0); // R6

    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !up_en |=> tbl_q == $past(tbl_q)); // R9
endmodule

// File: tb/test_stride_value_predictor.sv
module test_stride_value_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [63:0] lk_pred;
    logic        up_en = 1'b0;
    logic [31:0] up_pc = '0;
    logic [63:0] up_value = '0;

    int total = 0;
    int bad = 0;
    bit done = 0;

    bit          m_v[16];
    logic [25:0] m_tag[16];
    logic [63:0] m_last[16], m_s1[16], m_s2[16];

    always #5 clk = ~clk;

    stride_value_predictor i_stride_value_predictor (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hit(lk_hit), .lk_pred(lk_pred),
        .up_en(up_en), .up_pc(up_pc), .up_value(up_value)
    );

    task automatic report(input string rq, input bit ok, input logic [64:0] act, input logic [64:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual hit/pred=%h expected=%h", rq, act, exp);
        end
    endtask

    // Compare ports with the model, then advance one clock while the model takes the update.
    task automatic step(input logic [31:0] lpc, input bit ue, input logic [31:0] upc,
                        input logic [63:0] uval, input string rq);
        int li, ui;
        bit eh;
        logic [63:0] ep, d;
        lk_pc = lpc; up_en = ue; up_pc = upc; up_value = uval;
        #1;
        li = int'(lpc[5:2]);
        eh = m_v[li] && (m_tag[li] == lpc[31:6]);
        ep = eh ? m_last[li] + m_s2[li] : 64'd0;
        report(rq, (lk_hit === eh) && (lk_pred === ep), {lk_hit, lk_pred}, {eh, ep});
        if (ue) begin
            ui = int'(upc[5:2]);
            if (m_v[ui] && m_tag[ui] == upc[31:6]) begin
                d = uval - m_last[ui];
                if (d == m_s1[ui]) m_s2[ui] = d;
                m_s1[ui] = d;
            end else begin
                m_v[ui] = 1; m_tag[ui] = upc[31:6]; m_s1[ui] = 0; m_s2[ui] = 0;
            end
            m_last[ui] = uval;
        end
        @(negedge clk);
    endtask

    task automatic expect_pred(input logic [31:0] pc, input bit eh, input logic [63:0] ep, input string rq);
        lk_pc = pc; up_en = 1'b0;
        #1;
        report(rq, (lk_hit === eh) && (lk_pred === ep), {lk_hit, lk_pred}, {eh, ep});
    endtask

    task automatic feed(input logic [31:0] pc, input logic [63:0] val, input string rq);
        step(pc, 1'b1, pc, val, rq);
    endtask

    localparam logic [31:0] PA = 32'h0000_1000;
    localparam logic [31:0] PB = 32'h0000_1004;
    localparam logic [31:0] PD = 32'h0000_1008;
    localparam logic [31:0] PE = 32'h0000_100C;
    localparam logic [31:0] PX = 32'h0000_2000; // aliases PA's row

    initial begin
        for (int i = 0; i < 16; i++) begin
            m_v[i] = 0; m_tag[i] = '0; m_last[i] = '0; m_s1[i] = '0; m_s2[i] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty table after reset
        step(PA, 0, PA, 0, "R1");
        step(PX, 0, PA, 0, "R1");
        expect_pred(32'hFFFF_FFFC, 0, 64'd0, "R1");
        // R7: arithmetic sequence 1,2,3 -> 4
        feed(PA, 64'd1, "R6"); feed(PA, 64'd2, "R4"); feed(PA, 64'd3, "R5");
        expect_pred(PA, 1, 64'd4, "R7");
        // R2: a different tag in the same row misses
        expect_pred(PX, 0, 64'd0, "R2");
        // R7: constant sequence
        feed(PB, 64'd42, "R6"); feed(PB, 64'd42, "R4"); feed(PB, 64'd42, "R5");
        expect_pred(PB, 1, 64'd42, "R7");
        // R5: one-off jump 10,20,30,95,105 keeps stride 10
        feed(PD, 64'd10, "R6"); feed(PD, 64'd20, "R4"); feed(PD, 64'd30, "R5");
        expect_pred(PD, 1, 64'd40, "R3");
        feed(PD, 64'd95, "R5");
        expect_pred(PD, 1, 64'd105, "R5");
        feed(PD, 64'd105, "R5");
        expect_pred(PD, 1, 64'd115, "R5");
        // R8: negative stride and wraparound
        feed(PE, 64'd100, "R8"); feed(PE, 64'd97, "R8"); feed(PE, 64'd94, "R8");
        expect_pred(PE, 1, 64'd91, "R8");
        feed(PB, 64'hFFFF_FFFF_FFFF_FFFE, "R8"); feed(PB, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
        feed(PB, 64'd0, "R8");
        expect_pred(PB, 1, 64'd1, "R8");
        // R9: lookup in the same cycle as an update sees the old row
        step(PA, 1, PA, 64'd4, "R9");
        expect_pred(PA, 1, 64'd5, "R9");
        step(PA, 0, PA, 0, "R9");
        expect_pred(PA, 1, 64'd5, "R9");
        // R6: eviction by an aliasing address
        feed(PX, 64'd500, "R6");
        expect_pred(PX, 1, 64'd500, "R6");
        expect_pred(PA, 0, 64'd0, "R6");
        // Mixed random traffic, compared every cycle
        for (int n = 0; n < 400; n++) begin
            logic [31:0] pcs[5];
            logic [63:0] v;
            int k;
            pcs[0] = PA; pcs[1] = PB; pcs[2] = PX; pcs[3] = PD; pcs[4] = 32'h0000_3000;
            k = int'($urandom_range(0, 4));
            v = ($urandom_range(0, 3) == 0) ? {$urandom, $urandom} : 64'(n * 3);
            step(pcs[$urandom_range(0, 4)], $urandom_range(0, 3) != 0, pcs[k], v, "R3");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            total++; bad++;
            $display("FAIL R9: watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule